// File: doc/BRIEF.md
# Serial EEPROM Slave with Page Staging

This block is a two-wire serial-bus slave that makes a byte-wide memory array look like a serial EEPROM. It watches the clock and data lines, which it samples with the system clock. It finds START and STOP conditions and compares the received device address with three strap inputs. It then takes a two-byte word address followed by data bytes to write, or it returns bytes from the array. The data line is open-drain: the block reports it only as an input value plus a pull-low enable.

Written bytes do not go to the array straight away. They collect in a 32-byte page staging buffer. The STOP that closes a write sequence starts a self-timed commit that moves the staged bytes into the array. For a parameterized number of clock cycles after that, the slave does not answer its own address. A write-protect input lets a master run the whole write protocol without changing anything.

Top module: `ser_eeprom_slave`

## Requirements
- R1: A device address byte is acknowledged only when its top seven bits equal 4'b1010 followed by `strap[2:0]`, and only when no commit is running. Bit 0 is the direction: 0 means write and 1 means read. On a mismatch the data line stays released.
- R2: A write sequence carries two word-address bytes, high byte first. The array pointer is the low ADDR_W bits of the two bytes (12 by default, 13 for an 8192-byte array).
- R3: A single data byte written and ended by STOP can be read back from its address once the commit has finished.
- R4: Data bytes in one write sequence go to consecutive buffer slots. Only the low 5 address bits advance, so the bytes wrap within the current 32-byte page. A 33rd or later byte overwrites the slot that the count wraps back to.
- R5: The commit starts only on a STOP that ends a write sequence holding at least one data byte. It keeps the slave busy for WR_CYCLES clocks, and the array is written only while the slave is busy.
- R6: While busy, the slave acknowledges no address and never pulls the data line low. After the busy time it acknowledges again.
- R7: When `wp` is high, data bytes are still acknowledged, but the STOP starts no commit: the slave is not busy and the array keeps its old contents.
- R8: A repeated START after the two word-address bytes, followed by a read address, returns the byte at that word address.
- R9: Reads advance the pointer by one per byte and wrap from the last array address to 0. A master NACK followed by STOP ends the read.
- R10: A read that has no word address returns the byte at the pointer left by the previous operation.
- R11: After reset the data line is released, no commit is running, and the pointer is 0.
- R12: The pull-low enable only turns on while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Data line value as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Address strap value this device answers to |
| wp | input | 1 | 1 blocks commits to the array |

## Verification
A table of device-address bytes covers a correct match and mismatches in each strap bit, in the fixed 1010 code, and in the top bits. This separates a full seven-bit compare from a partial one. Write patterns include one byte, a page that crosses the 32-byte boundary, a 34-byte overrun, and a write with protect set. Reading these back tells in-page wrap apart from linear increment, and overwrite apart from dropped bytes. Reads cover a random read after a repeated START, a sequential read across the top of the array, and a current-address read, so pointer retention and array-wide wrap are each seen on their own.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD, S_RACK
    } bus_st_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [6:0] rx, input logic [2:0] strap);
        return rx == {DEV_CODE, strap};
    endfunction

endpackage

// File: rtl/i2cee_bus_sense.sv
module i2cee_bus_sense
    import i2cee_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [1:0] scl_sy, sda_sy;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_i};
            sda_sy <= {sda_sy[0], sda_i};
            scl_q  <= scl_sy[1];
            sda_q  <= sda_sy[1];
        end
    end

    always_comb begin
        ev.scl   = scl_sy[1];
        ev.sda   = sda_sy[1];
        ev.rise  = scl_sy[1] & ~scl_q;
        ev.fall  = ~scl_sy[1] & scl_q;
        ev.start = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
        ev.stop  = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
    end
endmodule

// File: rtl/i2cee_page_buf.sv
module i2cee_page_buf #(
    parameter int PAGE   = 32,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(PAGE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              wdata,
    input  logic                    go,
    input  logic [ADDR_W-IDX_W-1:0] base,
    output logic                    arr_we,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic [7:0]              arr_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAGE - 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    logic [7:0]              slot [PAGE];
    logic [PAGE-1:0]         vld;
    logic                    walking;
    logic [IDX_W-1:0]        wi;
    logic [ADDR_W-IDX_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (we) slot[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld     <= '0;
            walking <= 1'b0;
            wi      <= '0;
            base_q  <= '0;
        end else begin
            if (clr)     vld      <= '0;
            else if (we) vld[idx] <= 1'b1;
            if (go) begin
                walking <= 1'b1;
                wi      <= '0;
                base_q  <= base;
            end else if (walking) begin
                wi <= wi + IDX_ONE;
                if (wi == IDX_LAST) walking <= 1'b0;
            end
        end
    end

    assign arr_we   = walking & vld[wi];
    assign arr_addr = {base_q, wi};
    assign arr_data = slot[wi];
endmodule

// File: rtl/i2cee_wr_timer.sv
module i2cee_wr_timer #(
    parameter int WR_CYCLES = 500000,
    localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (go)   cnt <= CNT_W'(WR_CYCLES);
        else if (busy) cnt <= cnt - CNT_W'(1);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/i2cee_array.sv
module i2cee_array #(
    parameter int ADDR_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
    import i2cee_pkg::*;
#(
    parameter int ADDR_W    = 12,      // 9..16; 13 gives an 8192-byte array
    parameter int PAGE      = 32,
    parameter int WR_CYCLES = 500000   // must be at least PAGE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap,
    input  logic       wp
);
    localparam int IDX_W = $clog2(PAGE);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [IDX_W-1:0]  I_ONE = IDX_W'(1);

    bus_ev_t           ev;
    bus_st_t           st;
    logic [7:0]        sh;
    logic [3:0]        bcnt;
    logic              ack_ph;
    logic [ADDR_W-1:0] ptr;
    logic              have_data;
    logic              busy;
    logic [7:0]        rd_byte;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_data;
    logic              byte_in, buf_we, buf_clr, commit_go;

    i2cee_bus_sense u_sense (.clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev));

    // a full received byte is acted on at the falling edge after its 8th bit
    assign byte_in   = ev.fall & ~ack_ph & (bcnt == 4'd8);
    assign buf_we    = byte_in & (st == S_WR);
    assign buf_clr   = byte_in & (st == S_ALO);
    assign commit_go = ev.stop & (st == S_WR) & have_data & ~wp & ~busy;

    i2cee_page_buf #(.PAGE(PAGE), .ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we),
        .idx(ptr[IDX_W-1:0]), .wdata(sh), .go(commit_go),
        .base(ptr[ADDR_W-1:IDX_W]),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    i2cee_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (.clk(clk), .rst(rst), .go(commit_go), .busy(busy));

    i2cee_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .we(arr_we), .waddr(arr_addr), .wdata(arr_data),
        .raddr(ptr), .rdata(rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            sh        <= '0;
            bcnt      <= '0;
            ack_ph    <= 1'b0;
            sda_oe    <= 1'b0;
            ptr       <= '0;
            have_data <= 1'b0;
        end else if (ev.stop) begin
            st        <= S_IDLE;
            sda_oe    <= 1'b0;
            ack_ph    <= 1'b0;
            have_data <= 1'b0;
        end else if (ev.start) begin
            st        <= S_DEV;
            bcnt      <= '0;
            sda_oe    <= 1'b0;
            ack_ph    <= 1'b0;
            have_data <= 1'b0;
        end else if (ev.rise) begin
            case (st)
                S_DEV, S_AHI, S_ALO, S_WR:
                    if (!ack_ph) begin
                        sh   <= {sh[6:0], ev.sda};
                        bcnt <= bcnt + 4'd1;
                    end
                S_RACK: begin
                    st   <= ev.sda ? S_IDLE : S_RD;
                    bcnt <= '0;
                end
                default: ;
            endcase
        end else if (ev.fall) begin
            if (ack_ph) begin
                ack_ph <= 1'b0;
                if (st == S_RD) begin
                    sda_oe <= ~rd_byte[7];
                    bcnt   <= 4'd1;
                end else begin
                    sda_oe <= 1'b0;
                end
            end else if (st == S_RD) begin
                if (bcnt == 4'd8) begin
                    sda_oe <= 1'b0;
                    st     <= S_RACK;
                    ptr    <= ptr + A_ONE;
                end else begin
                    sda_oe <= ~rd_byte[3'd7 - bcnt[2:0]];
                    bcnt   <= bcnt + 4'd1;
                end
            end else if (byte_in) begin
                bcnt <= '0;
                case (st)
                    S_DEV:
                        if (dev_hit(sh[7:1], strap) && !busy) begin
                            sda_oe <= 1'b1;
                            ack_ph <= 1'b1;
                            st     <= sh[0] ? S_RD : S_AHI;
                        end else begin
                            st <= S_IDLE;
                        end
                    S_AHI: begin
                        ptr[ADDR_W-1:8] <= sh[ADDR_W-9:0];
                        sda_oe <= 1'b1;
                        ack_ph <= 1'b1;
                        st     <= S_ALO;
                    end
                    S_ALO: begin
                        ptr[7:0] <= sh;
                        sda_oe   <= 1'b1;
                        ack_ph   <= 1'b1;
                        st       <= S_WR;
                    end
                    S_WR: begin
                        ptr[IDX_W-1:0] <= ptr[IDX_W-1:0] + I_ONE;
                        have_data      <= 1'b1;
                        sda_oe         <= 1'b1;
                        ack_ph         <= 1'b1;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cee_checker.sv
module i2cee_checker (
    input logic clk,
    input logic rst,
    input logic wp,
    input logic sda_oe,
    input logic scl_s,
    input logic busy,
    input logic arr_we
);
    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    p_commit_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    p_array_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    p_wp_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wp));

    p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind ser_eeprom_slave i2cee_checker u_chk (
    .clk(clk), .rst(rst), .wp(wp), .sda_oe(sda_oe),
    .scl_s(ev.scl), .busy(busy), .arr_we(arr_we)
);

// File: tb/sim_ser_eeprom_slave.sv
module sim_ser_eeprom_slave;
    localparam int Q   = 10;
    localparam int WRC = 1000;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    // device byte, expected ACK (R1)
    localparam logic [8:0] DEV_VEC [8] = '{
        {8'hAA, 1'b1}, {8'hA8, 1'b0}, {8'hAE, 1'b0}, {8'hA2, 1'b0},
        {8'hBA, 1'b0}, {8'h2A, 1'b0}, {8'hEA, 1'b0}, {8'hAA, 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
    logic sda_oe;
    wire  sda_line = ~(m_low | sda_oe);
    int   nchk = 0, nerr = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    ser_eeprom_slave #(.ADDR_W(12), .PAGE(32), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap(STRAP), .wp(wp)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qw(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        end
        m_low = 1'b0; qw(); scl = 1'b1; qw(); ack = ~sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
        end
        m_low = ~nack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        m_low = 1'b0;
    endtask

    task automatic wr_seq(input logic [11:0] a, input logic [7:0] v0, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack);            chk({tag, " dev ack"}, ack, 1);
        send_byte({4'h0, a[11:8]}, ack);  chk({tag, " addr hi ack"}, ack, 1);
        send_byte(a[7:0], ack);           chk({tag, " addr lo ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(v0 + 8'(i), ack);
            if (i == 0 || i == n - 1) chk({tag, " data ack"}, ack, 1);
        end
        bus_stop();
    endtask

    task automatic wait_commit(); repeat (WRC + 60) @(negedge clk); endtask

    // random read setup: word address then repeated START and read address (R8)
    task automatic rd_open(input logic [11:0] a);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte({4'h0, a[11:8]}, ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(DEV_R, ack); chk("R8 read address ack", ack, 1);
    endtask

    task automatic rd_next(input logic last, input logic [7:0] exp, input string tag);
        logic [7:0] b;
        recv_byte(last, b);
        chk(tag, b, exp);
    endtask

    initial begin
        logic ack;
        repeat (4) @(negedge clk);
        chk("R11 released in reset", sda_oe, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 released after reset", sda_oe, 0);

        // R1 address match table; R5 an address-only write commits nothing
        foreach (DEV_VEC[k]) begin
            bus_start();
            send_byte(DEV_VEC[k][8:1], ack);
            chk("R1 device address match", ack, DEV_VEC[k][0]);
            bus_stop();
            qw();
        end

        // R3 byte write and read back, R6 busy NACK
        wr_seq(12'h0F0, 8'h3C, 1, "R3 byte write");
        bus_start(); send_byte(DEV_W, ack); chk("R6 no ack while busy", ack, 0); bus_stop();
        chk("R6 line released while busy", sda_oe, 0);
        wait_commit();
        bus_start(); send_byte(DEV_W, ack); chk("R6 ack after busy", ack, 1); bus_stop();
        rd_open(12'h0F0); rd_next(1'b1, 8'h3C, "R3 byte read back"); bus_stop();

        // bytes used by the later current-address test (R2 two-byte address)
        wr_seq(12'h123, 8'hA5, 2, "R2 write 0x123");
        wait_commit();

        // R4 page wrap: offset 30 with 4 bytes
        wr_seq(12'h41E, 8'h10, 4, "R4 page wrap write");
        wait_commit();
        rd_open(12'h41E);
        rd_next(1'b0, 8'h10, "R4 byte at 0x41E");
        rd_next(1'b1, 8'h11, "R9 increment to 0x41F");
        bus_stop();
        rd_open(12'h400);
        rd_next(1'b0, 8'h12, "R4 wrapped byte at 0x400");
        rd_next(1'b1, 8'h13, "R4 wrapped byte at 0x401");
        bus_stop();

        // R4 overrun: 34 bytes at page 0x200
        wr_seq(12'h200, 8'h00, 34, "R4 overrun write");
        wait_commit();
        rd_open(12'h200);
        rd_next(1'b0, 8'h20, "R4 slot 0 overwritten");
        rd_next(1'b0, 8'h21, "R4 slot 1 overwritten");
        rd_next(1'b1, 8'h02, "R4 slot 2 kept");
        bus_stop();
        rd_open(12'h21F); rd_next(1'b1, 8'h1F, "R4 last slot"); bus_stop();

        // R7 write protect
        wp = 1'b1;
        wr_seq(12'h123, 8'h5A, 1, "R7 protected write");
        bus_start(); send_byte(DEV_W, ack); chk("R7 no busy after protected stop", ack, 1); bus_stop();
        wp = 1'b0;
        wait_commit();
        rd_open(12'h123); rd_next(1'b1, 8'hA5, "R7 array unchanged"); bus_stop();

        // R10 current address read after random read of 0x123
        bus_start(); send_byte(DEV_R, ack); chk("R10 current read ack", ack, 1);
        rd_next(1'b1, 8'hA6, "R10 current address byte");
        bus_stop();

        // R9 wrap across the top of the array
        wr_seq(12'hFFF, 8'h77, 1, "R9 write top");
        wait_commit();
        wr_seq(12'h000, 8'h88, 1, "R9 write bottom");
        wait_commit();
        rd_open(12'hFFF);
        rd_next(1'b0, 8'h77, "R9 byte at top");
        rd_next(1'b1, 8'h88, "R9 wrapped to 0");
        bus_stop();
        chk("R9 released after NACK and STOP", sda_oe, 0);

        // R11 reset returns pointer to 0
        wr_seq(12'h0F0, 8'h3C, 1, "R11 pre-reset write");
        wait_commit();
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);
        bus_start(); send_byte(DEV_R, ack); chk("R11 ack after reset", ack, 1);
        rd_next(1'b1, 8'h88, "R11 pointer is 0 after reset");
        bus_stop();

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (190000) @(posedge clk);
                nchk++; nerr++;
                $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule